// File: doc/BRIEF.md
# Byte-enable bus cycle splitter

This block takes one operand request from a processor-side port and turns it into the physical bus cycles needed to move it. A request gives a byte address, an operand size of 1, 2 or 4 bytes, a read/write flag and write data. Each physical cycle drives a dword address (bits 31 to 2) with four active-low byte-lane enables. When a request spans two dwords, it becomes two dword cycles, and the dword holding the higher-addressed bytes goes first.

When the 16-bit width input is high at request acceptance, each dword cycle whose active bytes fall in both 16-bit halves is split into two cycles, lower half first. Every cycle also carries a word-select line (high for the upper half) and separate active-low high-byte and low-byte strobes for a 16-bit device. Write bytes are steered onto their address lanes, and upper-half bytes are mirrored onto bits 15:0. Read bytes are gathered across cycles and returned in address order.

The request side is valid/ready. `req_ready` is high only while no operation is in progress, and a request is taken on a rising edge where `req_valid` and `req_ready` are both high. Back-pressure therefore lasts for the whole operation. The completion side is a single-cycle `rsp_valid` pulse that cannot be stalled. Each bus cycle is held until the bus returns `bus_ready`.

Top module: `bus_cycle_splitter`

## Requirements
- R1: After reset, `bus_cyc` and `rsp_valid` are low and `req_ready` is high. `req_ready` is low whenever a bus cycle is in progress, and a request is accepted only on an edge with `req_valid` and `req_ready` both high.
- R2: `bus_be_n[i]` is low exactly when byte lane i (data bits 8i+7..8i) of the addressed dword carries an operand byte. The lane is the byte address modulo 4. Every issued pattern has at least one active lane, and its active lanes are contiguous.
- R3: A request whose first and last byte lie in different dwords takes two dword cycles. The first uses `bus_addr` = address[31:2]+1 and the second uses address[31:2].
- R4: With 16-bit width latched and active lanes in both halves of a dword, that dword takes two cycles. The first enables only lanes 1:0 and the second enables only lanes 3:2.
- R5: Within a cycle, if lane 0 or lane 1 is active, `bus_a1` is 0, `bus_bhe_n` = not lane1 and `bus_ble_n` = not lane0. Otherwise `bus_a1` is 1, `bus_bhe_n` = not lane3 and `bus_ble_n` = not lane2.
- R6: A cycle's address, enables and write data hold steady while `bus_ready` is low. The block moves to the next cycle only after an edge with `bus_ready` high.
- R7: On writes, operand byte k appears on the lane of address+k. In a 16-bit cycle with `bus_a1` = 1, bits 31:16 are also copied onto bits 15:0.
- R8: On reads, `rsp_rdata` byte k holds the byte read for address+k, and bytes at or beyond the operand size are zero. In a 16-bit cycle with `bus_a1` = 1, the data is taken from `bus_rdata[15:0]`.
- R9: `rsp_valid` is high for exactly one cycle, namely the cycle after the edge that completes the last bus cycle. No further bus cycle is issued for that request.
- R10: `bus_size16` is sampled only at acceptance. Changing it during an operation does not alter that operation's cycles.
- R11: `req_size` encodes 0 as 1 byte, 1 as 2 bytes and 2 or 3 as 4 bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_addr | input | ADDR_W | Operand byte address |
| req_size | input | 2 | Operand size code |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write operand, byte 0 at the lowest address |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Assembled read operand |
| bus_size16 | input | 1 | Bus is 16 bits wide (sampled at acceptance) |
| bus_cyc | output | 1 | Bus cycle in progress |
| bus_addr | output | ADDR_W-2 | Dword address |
| bus_be_n | output | 4 | Active-low byte-lane enables |
| bus_we | output | 1 | Cycle is a write |
| bus_wdata | output | 32 | Steered write data |
| bus_rdata | input | 32 | Read data from the bus |
| bus_ready | input | 1 | Current cycle finishes at this edge |
| bus_a1 | output | 1 | Upper-word select for a 16-bit bus |
| bus_bhe_n | output | 1 | Active-low high byte strobe, 16-bit bus |
| bus_ble_n | output | 1 | Active-low low byte strobe, 16-bit bus |

## Verification
The first bus cycle appears one clock after the accepting edge. Each following cycle appears one clock after the edge on which `bus_ready` was high. `rsp_valid` and the read data are due one clock after the edge that ends the last cycle. The bench drives all inputs on the falling edge and samples every output on the next falling edge, so each check lands in the cycle where its value is due. It inserts random wait cycles, during which it checks that the cycle holds steady. It also toggles `bus_size16` mid-operation, and it confirms after the last cycle that `bus_cyc` has dropped with no further cycle issued.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
  localparam int MAX_CYC = 4;
  localparam int IDX_W   = $clog2(MAX_CYC);
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam int LANES   = 4;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WRSV = 2'd3
  } op_size_e;

  // one physical cycle: which dword of the window, lanes active (high true)
  typedef struct packed {
    logic             upper_dw;
    logic [LANES-1:0] lanes;
  } cyc_desc_t;
endpackage

// File: rtl/bcs_planner.sv
module bcs_planner
  import bcs_pkg::*;
(
  input  logic [1:0]                  offset,
  input  logic [1:0]                  size,
  input  logic                        half_bus,
  output cyc_desc_t [MAX_CYC-1:0]     plan,
  output logic [CNT_W-1:0]            n_cyc
);
  logic [2*LANES-1:0] win;
  logic [LANES-1:0]   len_m;
  logic [LANES-1:0]   dwl;
  int                 k;

  always_comb begin
    case (op_size_e'(size))
      SZ_BYTE: len_m = 4'b0001;
      SZ_HALF: len_m = 4'b0011;
      default: len_m = 4'b1111;
    endcase
    win  = {4'b0000, len_m} << offset;
    plan = '0;
    k    = 0;
    dwl  = '0;
    // higher dword first, then the lower one
    for (int d = 1; d >= 0; d--) begin
      dwl = (d == 1) ? win[7:4] : win[3:0];
      if (dwl != '0) begin
        if (half_bus && (|dwl[1:0]) && (|dwl[3:2])) begin
          plan[k[IDX_W-1:0]] = '{upper_dw: d[0], lanes: {2'b00, dwl[1:0]}};
          k = k + 1;
          plan[k[IDX_W-1:0]] = '{upper_dw: d[0], lanes: {dwl[3:2], 2'b00}};
          k = k + 1;
        end else begin
          plan[k[IDX_W-1:0]] = '{upper_dw: d[0], lanes: dwl};
          k = k + 1;
        end
      end
    end
  end

  assign n_cyc = k[CNT_W-1:0];
endmodule

// File: rtl/bcs_dec16.sv
module bcs_dec16 (
  input  logic [3:0] lanes,
  output logic       a1,
  output logic       bhe_n,
  output logic       ble_n
);
  always_comb begin
    if (|lanes[1:0]) begin
      a1    = 1'b0;
      bhe_n = ~lanes[1];
      ble_n = ~lanes[0];
    end else begin
      a1    = 1'b1;
      bhe_n = ~lanes[3];
      ble_n = ~lanes[2];
    end
  end
endmodule

// File: rtl/bcs_lanes.sv
module bcs_lanes (
  input  logic [1:0]  offset,
  input  logic [31:0] op_wdata,
  input  logic        upper_dw,
  input  logic        upper_half16,
  input  logic [31:0] bus_rdata,
  output logic [31:0] bus_wdata,
  output logic [31:0] rd_lanes
);
  logic [63:0] win;
  logic [31:0] dw;

  always_comb begin
    win       = {32'h0, op_wdata} << {offset, 3'b000};
    dw        = upper_dw ? win[63:32] : win[31:0];
    bus_wdata = upper_half16 ? {dw[31:16], dw[31:16]} : dw;
    rd_lanes  = upper_half16 ? {bus_rdata[15:0], bus_rdata[15:0]} : bus_rdata;
  end
endmodule

// File: rtl/bus_cycle_splitter.sv
module bus_cycle_splitter
  import bcs_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic              req_write,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  input  logic              bus_size16,
  output logic              bus_cyc,
  output logic [ADDR_W-1:2] bus_addr,
  output logic [3:0]        bus_be_n,
  output logic              bus_we,
  output logic [31:0]       bus_wdata,
  input  logic [31:0]       bus_rdata,
  input  logic              bus_ready,
  output logic              bus_a1,
  output logic              bus_bhe_n,
  output logic              bus_ble_n
);
  localparam int DW_W = ADDR_W - 2;

  cyc_desc_t [MAX_CYC-1:0] plan_nx, plan_r;
  logic [CNT_W-1:0]        n_nx, n_r;
  logic [IDX_W-1:0]        ptr;
  logic                    busy, s16_r, wr_r;
  logic [1:0]              off_r, size_r;
  logic [DW_W-1:0]         base_r;
  logic [31:0]             wdata_r;
  logic [63:0]             rbuf;
  logic [63:0]             rsh;
  logic [31:0]             len_m32;
  logic [31:0]             rd_lanes;
  cyc_desc_t               cur;
  logic                    accept, step, last;

  bcs_planner u_plan (
    .offset   (req_addr[1:0]),
    .size     (req_size),
    .half_bus (bus_size16),
    .plan     (plan_nx),
    .n_cyc    (n_nx)
  );

  assign cur    = plan_r[ptr];
  assign accept = req_valid && !busy;
  assign step   = busy && bus_ready;
  assign last   = ({1'b0, ptr} == (n_r - CNT_W'(1)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      rsp_valid <= 1'b0;
      ptr       <= '0;
      n_r       <= '0;
      plan_r    <= '0;
      s16_r     <= 1'b0;
      wr_r      <= 1'b0;
      off_r     <= '0;
      size_r    <= '0;
      base_r    <= '0;
      wdata_r   <= '0;
      rbuf      <= '0;
    end else begin
      rsp_valid <= 1'b0;
      if (accept) begin
        busy    <= 1'b1;
        ptr     <= '0;
        n_r     <= n_nx;
        plan_r  <= plan_nx;
        s16_r   <= bus_size16;
        wr_r    <= req_write;
        off_r   <= req_addr[1:0];
        size_r  <= req_size;
        base_r  <= req_addr[ADDR_W-1:2];
        wdata_r <= req_wdata;
        rbuf    <= '0;
      end else if (step) begin
        if (!wr_r) begin
          for (int i = 0; i < LANES; i++) begin
            if (cur.lanes[i])
              rbuf[{cur.upper_dw, i[1:0], 3'b000} +: 8] <= rd_lanes[8*i +: 8];
          end
        end
        if (last) begin
          busy      <= 1'b0;
          rsp_valid <= 1'b1;
        end else begin
          ptr <= ptr + IDX_W'(1);
        end
      end
    end
  end

  bcs_lanes u_lanes (
    .offset       (off_r),
    .op_wdata     (wdata_r),
    .upper_dw     (cur.upper_dw),
    .upper_half16 (s16_r && (cur.lanes[1:0] == 2'b00)),
    .bus_rdata    (bus_rdata),
    .bus_wdata    (bus_wdata),
    .rd_lanes     (rd_lanes)
  );

  bcs_dec16 u_dec (
    .lanes (cur.lanes),
    .a1    (bus_a1),
    .bhe_n (bus_bhe_n),
    .ble_n (bus_ble_n)
  );

  always_comb begin
    case (op_size_e'(size_r))
      SZ_BYTE: len_m32 = 32'h0000_00FF;
      SZ_HALF: len_m32 = 32'h0000_FFFF;
      default: len_m32 = 32'hFFFF_FFFF;
    endcase
    rsh = rbuf >> {off_r, 3'b000};
  end

  assign rsp_rdata = rsh[31:0] & len_m32;
  assign req_ready = !busy;
  assign bus_cyc   = busy;
  assign bus_we    = wr_r;
  assign bus_be_n  = ~cur.lanes;
  assign bus_addr  = base_r + {{(DW_W-1){1'b0}}, cur.upper_dw};
endmodule

// File: rtl/bcs_checker.sv
module bcs_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              bus_cyc,
  input logic              bus_ready,
  input logic [ADDR_W-1:2] bus_addr,
  input logic [3:0]        bus_be_n,
  input logic [31:0]       bus_wdata,
  input logic              bus_a1
);
  function automatic logic contig(input logic [3:0] m);
    case (m)
      4'b0001, 4'b0010, 4'b0100, 4'b1000,
      4'b0011, 4'b0110, 4'b1100,
      4'b0111, 4'b1110, 4'b1111: return 1'b1;
      default:                   return 1'b0;
    endcase
  endfunction

  AST_BUSY_BLOCKS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    bus_cyc |-> !req_ready); // R1
  AST_BE_CONTIG: assert property (@(posedge clk) disable iff (!rst_n)
    bus_cyc |-> contig(~bus_be_n)); // R2
  AST_A1_LOW_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cyc && !bus_a1) |-> (bus_be_n[1:0] != 2'b11)); // R5
  AST_HOLD_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cyc && !bus_ready) |=> (bus_cyc && $stable(bus_addr) && $stable(bus_be_n)
                                 && $stable(bus_wdata))); // R6
  AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R9
  AST_RSP_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($past(bus_cyc && bus_ready) && !bus_cyc)); // R9
endmodule

bind bus_cycle_splitter bcs_checker #(.ADDR_W(ADDR_W)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .bus_cyc   (bus_cyc),
  .bus_ready (bus_ready),
  .bus_addr  (bus_addr),
  .bus_be_n  (bus_be_n),
  .bus_wdata (bus_wdata),
  .bus_a1    (bus_a1)
);

// File: tb/test_bus_cycle_splitter.sv
module test_bus_cycle_splitter;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready, req_write;
  logic [31:0] req_addr, req_wdata;
  logic [1:0]  req_size;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        bus_size16, bus_cyc, bus_we, bus_ready;
  logic [31:2] bus_addr;
  logic [3:0]  bus_be_n;
  logic [31:0] bus_wdata, bus_rdata;
  logic        bus_a1, bus_bhe_n, bus_ble_n;
  int          total = 0;
  int          bad   = 0;
  bit          finished = 1'b0;

  always #4 clk = ~clk;

  bus_cycle_splitter #(.ADDR_W(32)) i_bus_cycle_splitter (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_size(req_size), .req_write(req_write), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .bus_size16(bus_size16), .bus_cyc(bus_cyc), .bus_addr(bus_addr),
    .bus_be_n(bus_be_n), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_ready(bus_ready),
    .bus_a1(bus_a1), .bus_bhe_n(bus_bhe_n), .bus_ble_n(bus_ble_n)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] mbyte(input logic [31:0] a);
    return (a[7:0] * 8'd37) ^ a[15:8] ^ 8'hC3;
  endfunction

  // expected {a1, bhe_n, ble_n} for an active-low enable pattern (R5 table)
  function automatic logic [2:0] exp_dec(input logic [3:0] ben);
    case (ben)
      4'b1110: return 3'b010;
      4'b1101: return 3'b001;
      4'b1100: return 3'b000;
      4'b1011: return 3'b110;
      4'b0011: return 3'b100;
      4'b0111: return 3'b101;
      4'b1001, 4'b1000, 4'b0001, 4'b0000: return {1'b0, ben[1], ben[0]};
      default: return 3'b111;
    endcase
  endfunction

  task automatic do_op(input logic [31:0] addr, input logic [1:0] size,
                       input bit we, input logic [31:0] wd, input bit s16);
    int          len;
    int          ndw;
    int          ne;
    logic [31:0] lastb;
    logic [29:0] dws [2];
    logic [29:0] e_dw [4];
    logic [3:0]  e_ln [4];
    logic [31:0] exp_rd;
    len   = (size == 2'd0) ? 1 : (size == 2'd1) ? 2 : 4;
    lastb = addr + len - 1;
    ne    = 0;
    if (lastb[31:2] != addr[31:2]) begin
      dws[0] = lastb[31:2]; dws[1] = addr[31:2]; ndw = 2;
    end else begin
      dws[0] = addr[31:2]; dws[1] = '0; ndw = 1;
    end
    for (int j = 0; j < ndw; j++) begin
      logic [3:0] ln;
      ln = '0;
      for (int b = 0; b < len; b++) begin
        logic [31:0] ba;
        ba = addr + b;
        if (ba[31:2] == dws[j]) ln[ba[1:0]] = 1'b1;
      end
      if (s16 && ln[1:0] != 0 && ln[3:2] != 0) begin
        e_dw[ne] = dws[j]; e_ln[ne] = {2'b00, ln[1:0]}; ne++;
        e_dw[ne] = dws[j]; e_ln[ne] = {ln[3:2], 2'b00}; ne++;
      end else begin
        e_dw[ne] = dws[j]; e_ln[ne] = ln; ne++;
      end
    end
    exp_rd = '0;
    for (int b = 0; b < len; b++) exp_rd[8*b +: 8] = mbyte(addr + b);

    @(negedge clk);
    chk(req_ready == 1'b1, "R1", "req_ready idle", {31'b0, req_ready}, 32'd1);
    req_valid = 1'b1; req_addr = addr; req_size = size;
    req_write = we; req_wdata = wd; bus_size16 = s16;
    @(negedge clk);
    req_valid = 1'b0;
    bus_size16 = $urandom_range(0, 1); // R10: ignored mid-operation
    for (int i = 0; i < ne; i++) begin
      logic [29:0] ha;
      logic [3:0]  hb;
      bit          uh;
      int          waits;
      uh = s16 && (e_ln[i][1:0] == 2'b00);
      chk(bus_cyc == 1'b1, "R9", "cycle count", {31'b0, bus_cyc}, 32'd1);
      chk(req_ready == 1'b0, "R1", "busy ready", {31'b0, req_ready}, 32'd0);
      chk(bus_addr == e_dw[i], (ndw == 2) ? "R3" : "R2", "dword addr",
          {2'b0, bus_addr}, {2'b0, e_dw[i]});
      chk(bus_be_n == ~e_ln[i], s16 ? "R4" : "R2", "byte enables",
          {28'b0, bus_be_n}, {28'b0, ~e_ln[i]});
      if (s16)
        chk({bus_a1, bus_bhe_n, bus_ble_n} == exp_dec(~e_ln[i]), "R5", "a1/bhe/ble",
            {29'b0, bus_a1, bus_bhe_n, bus_ble_n}, {29'b0, exp_dec(~e_ln[i])});
      chk(bus_we == we, "R7", "write flag", {31'b0, bus_we}, {31'b0, we});
      if (we) begin
        for (int l = 0; l < 4; l++) begin
          if (e_ln[i][l]) begin
            logic [31:0] off;
            logic [7:0]  eb;
            off = {e_dw[i], l[1:0]} - addr;
            eb  = wd[8*off[1:0] +: 8];
            chk(bus_wdata[8*l +: 8] == eb, "R7", "write lane",
                {24'b0, bus_wdata[8*l +: 8]}, {24'b0, eb});
            if (uh)
              chk(bus_wdata[8*(l-2) +: 8] == eb, "R7", "upper mirror",
                  {24'b0, bus_wdata[8*(l-2) +: 8]}, {24'b0, eb});
          end
        end
      end
      ha = bus_addr; hb = bus_be_n;
      waits = $urandom_range(0, 2);
      for (int w = 0; w < waits; w++) begin
        @(negedge clk);
        chk(bus_cyc && bus_addr == ha && bus_be_n == hb, "R6", "hold while waiting",
            {bus_cyc, bus_addr[28:2], bus_be_n}, {1'b1, ha[26:0], hb});
        chk(rsp_valid == 1'b0, "R6", "no early completion", {31'b0, rsp_valid}, 32'd0);
      end
      if (uh)
        bus_rdata = {16'hBEEF, mbyte({e_dw[i], 2'd3}), mbyte({e_dw[i], 2'd2})};
      else
        bus_rdata = {mbyte({e_dw[i], 2'd3}), mbyte({e_dw[i], 2'd2}),
                     mbyte({e_dw[i], 2'd1}), mbyte({e_dw[i], 2'd0})};
      bus_ready = 1'b1;
      @(negedge clk);
      bus_ready = 1'b0;
      bus_rdata = 32'hA5A5_5A5A;
    end
    chk(rsp_valid == 1'b1, "R9", "completion pulse", {31'b0, rsp_valid}, 32'd1);
    chk(bus_cyc == 1'b0, "R9", "no extra cycle", {31'b0, bus_cyc}, 32'd0);
    if (!we)
      chk(rsp_rdata == exp_rd, "R8", "read operand", rsp_rdata, exp_rd);
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R9", "pulse width", {31'b0, rsp_valid}, 32'd0);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog run did not finish actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_size = '0;
    req_write = 1'b0; req_wdata = '0; bus_size16 = 1'b0;
    bus_ready = 1'b0; bus_rdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(bus_cyc == 1'b0, "R1", "reset bus_cyc", {31'b0, bus_cyc}, 32'd0);
    chk(rsp_valid == 1'b0, "R1", "reset rsp_valid", {31'b0, rsp_valid}, 32'd0);
    chk(req_ready == 1'b1, "R1", "reset req_ready", {31'b0, req_ready}, 32'd1);
    // directed: every size code (R11) x offset x width x direction
    for (int s = 0; s < 4; s++)
      for (int o = 0; o < 4; o++)
        for (int h = 0; h < 2; h++)
          for (int d = 0; d < 2; d++)
            do_op(32'h0000_1230 + o, s[1:0], d[0], 32'h4433_2211, h[0]);
    // directed: crossing into a new 64 KiB block
    do_op(32'h0001_FFFE, 2'd2, 1'b0, 32'h0, 1'b1);
    do_op(32'h0001_FFFF, 2'd1, 1'b1, 32'hCAFE_F00D, 1'b0);
    // constrained random
    for (int n = 0; n < 300; n++)
      do_op($urandom & 32'h0FFF_FFFF, 2'($urandom_range(0, 3)),
            1'($urandom_range(0, 1)), $urandom, 1'($urandom_range(0, 1)));
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule